// File: doc/BRIEF.md
# 8b/10b Line Encoder

This block turns a stream of bytes into DC-balanced 10-bit transmission symbols, one per accepted input, for a serial link. Each byte arrives with a flag that selects a data symbol or one of twelve control symbols. The low five bits are coded into a 6-bit group and the high three bits into a 4-bit group. A two-state running disparity picks the polarity of every group that is not balanced, so the line never drifts more than two bits from balance.

The running disparity is the block's state machine. It has two states: `RD_NEG` (disparity -1, the reset state) and `RD_POS` (disparity +1). Each group that is not balanced causes a transition: a 6- or 4-bit group with two more ones moves `RD_NEG` to `RD_POS`, and one with two more zeros moves `RD_POS` to `RD_NEG`. A balanced group keeps the state. The 6-bit group sees the state held in the register. The 4-bit group sees the state left after the 6-bit group. The register stores the state left after the 4-bit group. An unsupported control request raises an error flag, emits a fixed balanced symbol and leaves the state unchanged. One register stage lies between input and output.

Top module: `lc_enc8b10b`

## Requirements
- R1: While `rst_n` is low and after its release, `rd_pos_o` is 0 (disparity -1), `err_o` is 0 and `sym_o` is the balanced filler 10'b1010101010.
- R2: Input bit 0 is A and bit 7 is H. The 6-bit group abcdei occupies `sym_o[9:4]` and the 4-bit group fghj occupies `sym_o[3:0]`. Bit a is `sym_o[9]` and is sent first. Example: data 0x3F encodes to 10'b1010111001 from disparity -1 and to 10'b0101001001 from disparity +1.
- R3: An input with `in_valid` high appears on `sym_o`, `err_o` and `rd_pos_o` after the next rising clock edge. While `in_valid` is low, all three outputs hold their values.
- R4: A balanced group keeps the disparity. A group that is not balanced uses its ones-heavy form from -1 and its zeros-heavy form from +1, and it flips the disparity. Examples: data 0x07 gives 1110001011 from -1 and 0001110100 from +1. Data 0x63 gives 1100011100 from -1.
- R5: For data bytes whose high three bits are 7, the 4-bit group is 0111/1000 when the low five bits are 17, 18 or 20 at disparity -1, or 11, 13 or 14 at disparity +1. In every other case it is 1110/0001.
- R6: With `in_ctrl` high, the legal bytes are the eight with low five bits 28 (0x1C..0xFC), plus 0xF7, 0xFB, 0xFD and 0xFE. The 6-bit group for low bits 28 is 001111 from -1 and 110000 from +1. Example: 0xBC encodes to 0011111010 from -1 and 1100000101 from +1.
- R7: For control bytes whose high bits are 1, 2, 5 or 6, the 4-bit group is the complement of the data group. Control bytes whose high bits are 7 always use 0111/1000. Examples: 0x3C from -1 encodes to 0011111001. 0xFC from +1 encodes to 1100000111. 0xF7 from -1 encodes to 1110101000.
- R8: An illegal control byte with `in_valid` high sets `err_o` to 1 and `sym_o` to 1010101010, and it leaves `rd_pos_o` unchanged. The next legal input clears `err_o`.
- R9: Every symbol carries 4, 5 or 6 ones. A symbol with 6 ones leaves the disparity at +1, one with 4 leaves it at -1, and one with 5 leaves it unchanged. The sent stream never holds more than five equal bits in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte is present this cycle |
| in_byte | input | 8 | Byte to encode, bit 0 = A |
| in_ctrl | input | 1 | 1 = control symbol, 0 = data |
| sym_o | output | 10 | Encoded symbol, bit 9 sent first |
| rd_pos_o | output | 1 | Running disparity after `sym_o`: 1 = +1, 0 = -1 |
| err_o | output | 1 | Last accepted input was an illegal control byte |

## Verification
The block has no free parameters, so the bench builds it with the package defaults: a 10-bit symbol split into 6 and 4 bits. That brings the whole code space within reach. A sweep sends all 256 data bytes and all twelve control bytes back to back and checks each symbol's weight, the disparity update and the run length across symbol edges. Directed cases pin down exact code words for both disparity states, both 7-group choices, the complemented control groups, the illegal-control path and the hold behaviour when `in_valid` is low.

// File: rtl/lc8b10b_pkg.sv
package lc8b10b_pkg;
    localparam int LO_W   = 5;
    localparam int HI_W   = 3;
    localparam int G6_W   = LO_W + 1;
    localparam int G4_W   = HI_W + 1;
    localparam int BYTE_W = LO_W + HI_W;
    localparam int SYM_W  = G6_W + G4_W;
    localparam int G6_BAL = G6_W / 2;
    localparam int G4_BAL = G4_W / 2;
    localparam logic [SYM_W-1:0] FILLER_SYM = 10'b1010101010;

    typedef enum logic {RD_NEG = 1'b0, RD_POS = 1'b1} rd_t;

    function automatic rd_t rd_flip(input rd_t r);
        rd_t n;
        unique case (r)
            RD_NEG: n = RD_POS;
            RD_POS: n = RD_NEG;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/lc_grp6_enc.sv
module lc_grp6_enc
    import lc8b10b_pkg::*;
(
    input  logic [LO_W-1:0] x_i,
    input  logic            k28_i,
    input  rd_t             rd_i,
    output logic [G6_W-1:0] code_o,
    output rd_t             rd_o
);
    logic [G6_W-1:0] base;
    logic            flip;

    always_comb begin
        unique case (x_i)
            5'd0:  {flip, base} = {1'b1, 6'b100111};
            5'd1:  {flip, base} = {1'b1, 6'b011101};
            5'd2:  {flip, base} = {1'b1, 6'b101101};
            5'd3:  {flip, base} = {1'b0, 6'b110001};
            5'd4:  {flip, base} = {1'b1, 6'b110101};
            5'd5:  {flip, base} = {1'b0, 6'b101001};
            5'd6:  {flip, base} = {1'b0, 6'b011001};
            5'd7:  {flip, base} = {1'b1, 6'b111000};
            5'd8:  {flip, base} = {1'b1, 6'b111001};
            5'd9:  {flip, base} = {1'b0, 6'b100101};
            5'd10: {flip, base} = {1'b0, 6'b010101};
            5'd11: {flip, base} = {1'b0, 6'b110100};
            5'd12: {flip, base} = {1'b0, 6'b001101};
            5'd13: {flip, base} = {1'b0, 6'b101100};
            5'd14: {flip, base} = {1'b0, 6'b011100};
            5'd15: {flip, base} = {1'b1, 6'b010111};
            5'd16: {flip, base} = {1'b1, 6'b011011};
            5'd17: {flip, base} = {1'b0, 6'b100011};
            5'd18: {flip, base} = {1'b0, 6'b010011};
            5'd19: {flip, base} = {1'b0, 6'b110010};
            5'd20: {flip, base} = {1'b0, 6'b001011};
            5'd21: {flip, base} = {1'b0, 6'b101010};
            5'd22: {flip, base} = {1'b0, 6'b011010};
            5'd23: {flip, base} = {1'b1, 6'b111010};
            5'd24: {flip, base} = {1'b1, 6'b110011};
            5'd25: {flip, base} = {1'b0, 6'b100110};
            5'd26: {flip, base} = {1'b0, 6'b010110};
            5'd27: {flip, base} = {1'b1, 6'b110110};
            5'd28: {flip, base} = {1'b0, 6'b001110};
            5'd29: {flip, base} = {1'b1, 6'b101110};
            5'd30: {flip, base} = {1'b1, 6'b011110};
            5'd31: {flip, base} = {1'b1, 6'b101011};
        endcase
        if (k28_i) begin
            {flip, base} = {1'b1, 6'b001111};
        end
    end

    always_comb begin
        unique case (rd_i)
            RD_NEG: code_o = base;
            RD_POS: code_o = flip ? ~base : base;
        endcase
        rd_o = ($countones(base) != G6_BAL) ? rd_flip(rd_i) : rd_i;
    end
endmodule

// File: rtl/lc_grp4_enc.sv
module lc_grp4_enc
    import lc8b10b_pkg::*;
(
    input  logic [HI_W-1:0] y_i,
    input  logic [LO_W-1:0] x_i,
    input  logic            ctrl_i,
    input  rd_t             rd_i,
    output logic [G4_W-1:0] code_o,
    output rd_t             rd_o
);
    localparam logic [G4_W-1:0] PRI7 = 4'b1110;
    localparam logic [G4_W-1:0] ALT7 = 4'b0111;

    logic [G4_W-1:0] base;
    logic            flip;
    logic            use_alt;

    always_comb begin
        unique case (rd_i)
            RD_NEG: use_alt = (x_i == 5'd17) || (x_i == 5'd18) || (x_i == 5'd20);
            RD_POS: use_alt = (x_i == 5'd11) || (x_i == 5'd13) || (x_i == 5'd14);
        endcase
        if (ctrl_i) begin
            use_alt = 1'b1;
        end
    end

    always_comb begin
        unique case (y_i)
            3'd0: {flip, base} = {1'b1, 4'b1011};
            3'd1: {flip, base} = ctrl_i ? {1'b1, 4'b0110} : {1'b0, 4'b1001};
            3'd2: {flip, base} = ctrl_i ? {1'b1, 4'b1010} : {1'b0, 4'b0101};
            3'd3: {flip, base} = {1'b1, 4'b1100};
            3'd4: {flip, base} = {1'b1, 4'b1101};
            3'd5: {flip, base} = ctrl_i ? {1'b1, 4'b0101} : {1'b0, 4'b1010};
            3'd6: {flip, base} = ctrl_i ? {1'b1, 4'b1001} : {1'b0, 4'b0110};
            3'd7: {flip, base} = {1'b1, use_alt ? ALT7 : PRI7};
        endcase
    end

    always_comb begin
        unique case (rd_i)
            RD_NEG: code_o = base;
            RD_POS: code_o = flip ? ~base : base;
        endcase
        rd_o = ($countones(base) != G4_BAL) ? rd_flip(rd_i) : rd_i;
    end
endmodule

// File: rtl/lc_ctrl_legal.sv
module lc_ctrl_legal
    import lc8b10b_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              ctrl_i,
    output logic              bad_o,
    output logic              k28_o
);
    logic legal;

    always_comb begin
        k28_o = ctrl_i && (byte_i[LO_W-1:0] == 5'd28);
        legal = (byte_i[LO_W-1:0] == 5'd28)
             || (byte_i == 8'hF7) || (byte_i == 8'hFB)
             || (byte_i == 8'hFD) || (byte_i == 8'hFE);
        bad_o = ctrl_i && !legal;
    end
endmodule

// File: rtl/lc_enc8b10b.sv
module lc_enc8b10b
    import lc8b10b_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_ctrl,
    output logic [SYM_W-1:0]  sym_o,
    output logic              rd_pos_o,
    output logic              err_o
);
    rd_t             rd_q;
    rd_t             rd_nxt;
    rd_t             rd_mid;
    rd_t             rd_end;
    logic [G6_W-1:0] c6;
    logic [G4_W-1:0] c4;
    logic            bad;
    logic            k28;

    lc_ctrl_legal u_legal (
        .byte_i (in_byte),
        .ctrl_i (in_ctrl),
        .bad_o  (bad),
        .k28_o  (k28)
    );

    lc_grp6_enc u_g6 (
        .x_i    (in_byte[LO_W-1:0]),
        .k28_i  (k28),
        .rd_i   (rd_q),
        .code_o (c6),
        .rd_o   (rd_mid)
    );

    lc_grp4_enc u_g4 (
        .y_i    (in_byte[BYTE_W-1:LO_W]),
        .x_i    (in_byte[LO_W-1:0]),
        .ctrl_i (in_ctrl),
        .rd_i   (rd_mid),
        .code_o (c4),
        .rd_o   (rd_end)
    );

    always_comb begin
        rd_nxt = rd_q;
        if (in_valid && !bad) begin
            rd_nxt = rd_end;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= RD_NEG;
        end else begin
            rd_q <= rd_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_o <= FILLER_SYM;
            err_o <= 1'b0;
        end else if (in_valid) begin
            sym_o <= bad ? FILLER_SYM : {c6, c4};
            err_o <= bad;
        end
    end

    assign rd_pos_o = (rd_q == RD_POS);
endmodule

// File: rtl/lc_enc8b10b_chk.sv
module lc_enc8b10b_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [9:0] sym_o,
    input logic       rd_pos_o,
    input logic       err_o
);
    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sym_o) && $stable(rd_pos_o) && $stable(err_o)));

    // R8
    err_keeps_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(rd_pos_o));

    // R9
    sym_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sym_o) >= 4) && ($countones(sym_o) <= 6));

    // R9
    heavy_sets_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sym_o) == 6) |-> rd_pos_o);

    // R9
    light_sets_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sym_o) == 4) |-> !rd_pos_o);

    // R4
    balanced_keeps_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $countones(sym_o) == 5) |-> $stable(rd_pos_o));
endmodule

bind lc_enc8b10b lc_enc8b10b_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .sym_o    (sym_o),
    .rd_pos_o (rd_pos_o),
    .err_o    (err_o)
);

// File: tb/lc_enc8b10b_bench.sv
`timescale 1ns/1ps
module lc_enc8b10b_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ctrl = 1'b0;
    logic [9:0] sym_o;
    logic       rd_pos_o;
    logic       err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lc_enc8b10b u_lc_enc8b10b (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_ctrl  (in_ctrl),
        .sym_o    (sym_o),
        .rd_pos_o (rd_pos_o),
        .err_o    (err_o)
    );

    task automatic chk(input string tag, input logic [9:0] es, input logic er, input logic ee);
        n_chk++;
        if (sym_o !== es || rd_pos_o !== er || err_o !== ee) begin
            n_bad++;
            $display("FAIL %s: sym=%b rd=%b err=%b, expected sym=%b rd=%b err=%b",
                     tag, sym_o, rd_pos_o, err_o, es, er, ee);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic k);
        @(negedge clk);
        in_byte  = b;
        in_ctrl  = k;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", 10'b1010101010, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 10'b1010101010, 1'b0, 1'b0);
    endtask

    task automatic t_data();
        send(8'h3F, 1'b0); chk("R2 D31.1 neg", 10'b1010111001, 1'b1, 1'b0);
        send(8'h3F, 1'b0); chk("R2 D31.1 pos", 10'b0101001001, 1'b0, 1'b0);
        send(8'h00, 1'b0); chk("R4 D0.0 neg", 10'b1001110100, 1'b0, 1'b0);
        send(8'h07, 1'b0); chk("R4 D7.0 neg", 10'b1110001011, 1'b1, 1'b0);
        send(8'h07, 1'b0); chk("R4 D7.0 pos", 10'b0001110100, 1'b0, 1'b0);
        send(8'h63, 1'b0); chk("R4 D3.3 neg", 10'b1100011100, 1'b0, 1'b0);
    endtask

    task automatic t_alt7();
        send(8'hF1, 1'b0); chk("R5 D17.7 neg alt", 10'b1000110111, 1'b1, 1'b0);
        send(8'hF1, 1'b0); chk("R5 D17.7 pos pri", 10'b1000110001, 1'b0, 1'b0);
        send(8'hEB, 1'b0); chk("R5 D11.7 neg pri", 10'b1101001110, 1'b1, 1'b0);
        send(8'hEB, 1'b0); chk("R5 D11.7 pos alt", 10'b1101001000, 1'b0, 1'b0);
    endtask

    task automatic t_ctrl();
        send(8'hBC, 1'b1); chk("R6 K28.5 neg", 10'b0011111010, 1'b1, 1'b0);
        send(8'hBC, 1'b1); chk("R6 K28.5 pos", 10'b1100000101, 1'b0, 1'b0);
        send(8'hF7, 1'b1); chk("R7 K23.7 neg", 10'b1110101000, 1'b0, 1'b0);
        send(8'h3C, 1'b1); chk("R7 K28.1 neg", 10'b0011111001, 1'b1, 1'b0);
        send(8'hFC, 1'b1); chk("R7 K28.7 pos", 10'b1100000111, 1'b1, 1'b0);
    endtask

    task automatic t_illegal();
        send(8'h00, 1'b1); chk("R8 illegal K0.0", 10'b1010101010, 1'b1, 1'b1);
        send(8'hF9, 1'b1); chk("R8 illegal K25.7", 10'b1010101010, 1'b1, 1'b1);
        send(8'h3F, 1'b0); chk("R8 err clears", 10'b0101001001, 1'b0, 1'b0);
    endtask

    task automatic t_hold();
        @(negedge clk);
        in_byte = 8'hBC; in_ctrl = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 hold while idle", 10'b0101001001, 1'b0, 1'b0);
        send(8'h07, 1'b0); chk("R3 one-cycle update", 10'b1110001011, 1'b1, 1'b0);
    endtask

    task automatic t_sweep();
        logic last_bit;
        int   run;
        logic prev_rd;
        logic [7:0] kb [12];
        kb = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
               8'hF7, 8'hFB, 8'hFD, 8'hFE};
        last_bit = 1'bx;
        run = 0;
        for (int i = 0; i < 268; i++) begin
            logic ok;
            int   ones;
            int   maxrun;
            prev_rd = rd_pos_o;
            if (i < 256) send(i[7:0], 1'b0);
            else         send(kb[i-256], 1'b1);
            ones = $countones(sym_o);
            maxrun = 0;
            for (int b = 9; b >= 0; b--) begin
                if (sym_o[b] === last_bit) run++;
                else run = 1;
                last_bit = sym_o[b];
                if (run > maxrun) maxrun = run;
            end
            ok = (ones >= 4 && ones <= 6) && (err_o == 1'b0) && (maxrun <= 5);
            if (ones == 6) ok = ok && rd_pos_o;
            if (ones == 4) ok = ok && !rd_pos_o;
            if (ones == 5) ok = ok && (rd_pos_o == prev_rd);
            n_chk++;
            if (!ok) begin
                n_bad++;
                $display("FAIL R9 sweep item %0d: sym=%b rd=%b err=%b run=%0d, expected 4..6 ones, matching rd, run<=5, err=0",
                         i, sym_o, rd_pos_o, err_o, maxrun);
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_data();
        t_alt7();
        t_ctrl();
        t_illegal();
        t_hold();
        t_sweep();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule